// File: doc/BRIEF.md
# Serial Receive DMA Engine with Clock Backpressure

This block takes bytes arriving on a serial peripheral link and writes them into an on-chip byte FIFO without software moving any data. One of two serial data lines is chosen as the source. The engine can run as the clock master, generating SCK itself, or as a slave that follows an externally supplied SCK. A consumer on the far side of the FIFO drains it through a show-ahead pop port and can read the current fill level.

In master mode the engine protects the FIFO by stalling its own clock. When a byte finishes and the FIFO is full, SCK is frozen at the level opposite to CPOL until space frees. It then resumes on its own, so no byte is ever split. In slave mode the clock cannot be held back, so bytes that complete while the FIFO is full are discarded. The usable FIFO depth is set at run time from a 2-bit code. The SCK rate comes from a power-of-two prescaler.

Top module: `spi_rx_dma`

## Requirements
- R1: Capture runs only while `link_en`=1, `dma_en`=1 and `par_mode`=0. Otherwise no byte enters the FIFO and `sck_out` sits at `cpol` from the next cycle on.
- R2: `src_sel`=0 takes bits from `sdi0` and `src_sel`=1 from `sdi1`. Bits are shifted in MSB first, one per leading SCK edge. The leading edge is rising for `cpol`=0 and falling for `cpol`=1.
- R3: In master mode each SCK half period lasts 2^`div_code` clock cycles (1, 2, 4 or 8). The clock starts from the `cpol` level.
- R4: In master mode, when the FIFO is full right after a byte's eighth leading edge, `sck_out` holds at the inverse of `cpol` until the FIFO is no longer full, and then continues. If a byte completes while the FIFO is already full, that byte is discarded.
- R5: In slave mode (`master`=0), bits are sampled on leading edges of `sck_in`. A byte completing while the FIFO is full is dropped, and bytes completing after space frees are stored.
- R6: The FIFO limit is 8 << `len_code` (00:8, 01:16, 10:32, 11:64). `full` is high while `count` is at or above the limit, and no byte is written then.
- R7: `dir_tx`=1 (transmit direction) blocks every FIFO write and keeps `sck_out` at `cpol`.
- R8: `pop_valid` is high whenever the FIFO holds data, and `pop_data` shows the oldest byte. Asserting `pop` while `pop_valid` is high removes that byte, and `count` gives the occupancy.
- R9: While `rst_n` is low at a clock edge, the FIFO empties, `count` becomes 0 and `sck_out` takes the `cpol` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Serial link enable |
| dma_en | input | 1 | Serial-to-FIFO transfer enable |
| par_mode | input | 1 | Parallel capture selected; disables this engine when 1 |
| dir_tx | input | 1 | 1 = transmit direction, no capture |
| master | input | 1 | 1 = generate SCK, 0 = follow `sck_in` |
| src_sel | input | 1 | Selects the serial data line |
| cpol | input | 1 | Clock polarity |
| div_code | input | 2 | SCK prescaler select |
| len_code | input | 2 | FIFO depth select |
| sdi0 | input | 1 | Serial data line 0 |
| sdi1 | input | 1 | Serial data line 1 |
| sck_in | input | 1 | External SCK in slave mode, synchronous to `clk` |
| sck_out | output | 1 | Generated SCK |
| pop | input | 1 | Remove head byte |
| pop_valid | output | 1 | FIFO not empty |
| pop_data | output | 8 | Head byte |
| count | output | 7 | Bytes held |
| full | output | 1 | Occupancy at or above the selected depth |

## Verification
`sck_out` moves on the clock edge after the cycle in which the prescaler count reaches its end. A completed byte shows in `count` and `pop_valid` one edge after the cycle of its eighth leading edge. A stalled clock restarts one half period after the edge at which a pop lowers the fill level. A reference model in the bench steps on rising edges with the same inputs. Every output is compared with the model on falling edges, so each result is checked in exactly the cycle it becomes due. Explicit checks on parked levels, measured half periods and popped byte values are taken at the same falling-edge points.

// File: rtl/spi_rx_dma_pkg.sv
// Shared helpers for the serial receive DMA engine.
// Assumes depths are powers of two so that pointers wrap naturally.
package spi_rx_dma_pkg;
    localparam int BYTE_W = 8;

    // Depth limit selected by a length code: base, 2*base, 4*base, ...
    function automatic int unsigned depth_of(input int unsigned base, input int unsigned code);
        return base << code;
    endfunction
endpackage

// File: rtl/spi_rx_sck_gen.sv
// Master clock generator: a prescaled SCK that starts from the CPOL level.
// It stalls at the inverse level after a byte's last leading edge while the
// FIFO is full. Assumes cpol and div_code stay static while run is high.
module spi_rx_sck_gen #(
    parameter int DIV_W  = 2,
    parameter int DCNT_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div_code,
    input  logic             full,
    input  logic             at_boundary,
    output logic             sck,
    output logic             lead
);
    logic [DCNT_W-1:0] div_q;
    logic [DCNT_W-1:0] half_m1;
    logic              sck_q;
    logic              stall;
    logic              tick;

    assign half_m1 = DCNT_W'((32'd1 << div_code) - 32'd1);
    assign stall   = full & (sck_q != cpol) & at_boundary;
    assign tick    = run & ~stall & (div_q == half_m1);
    assign lead    = tick & (sck_q == cpol);
    assign sck     = sck_q;

    // Advance the prescaler and toggle SCK at each half-period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck_q <= cpol;
            div_q <= '0;
        end else if (stall) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + DCNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_rx_shifter.sv
// Bit assembler: shifts the selected data line in MSB first on each leading
// edge (master strobe or detected slave edge). It flags a complete byte.
// Assumes sck_in is already synchronous to clk.
module spi_rx_shifter
    import spi_rx_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              master,
    input  logic              cpol,
    input  logic              sck_in,
    input  logic              sdi,
    input  logic              m_lead,
    output logic              at_boundary,
    output logic              push,
    output logic [BYTE_W-1:0] push_data
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic              sck_in_q;
    logic              s_lead;
    logic              strobe;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;

    assign s_lead      = ~master & (sck_in_q == cpol) & (sck_in != cpol);
    assign strobe      = cap_en & (master ? m_lead : s_lead);
    assign push        = strobe & (bit_q == BIT_W'(BYTE_W - 1));
    assign push_data   = {sh_q[BYTE_W-2:0], sdi};
    assign at_boundary = (bit_q == '0);

    // Remember the previous external clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_in_q <= cpol;
        else        sck_in_q <= sck_in;
    end

    // Shift one bit per strobe and count bits within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cap_en) begin
            bit_q <= '0;
            sh_q  <= '0;
        end else if (strobe) begin
            bit_q <= bit_q + BIT_W'(1);
            sh_q  <= push_data;
        end
    end
endmodule

// File: rtl/spi_rx_fifo.sv
// Byte FIFO with a run-time depth limit and show-ahead read port.
// Assumes MAX_DEPTH is a power of two; writes are refused while full.
module spi_rx_fifo
    import spi_rx_dma_pkg::*;
#(
    parameter int MIN_DEPTH = 8,
    parameter int LEN_W     = 2,
    parameter int MAX_DEPTH = MIN_DEPTH << ((1 << LEN_W) - 1),
    parameter int CNT_W     = $clog2(MAX_DEPTH + 1),
    parameter int PTR_W     = $clog2(MAX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    logic [BYTE_W-1:0] mem [MAX_DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic              wr, rd;

    assign limit     = CNT_W'(depth_of(MIN_DEPTH, 32'(len_code)));
    assign full      = (cnt_q >= limit);
    assign wr        = push & ~full;
    assign rd        = pop & (cnt_q != '0);
    assign pop_valid = (cnt_q != '0);
    assign pop_data  = mem[rd_q];
    assign count     = cnt_q;

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (wr) mem[wr_q] <= push_data;
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr) wr_q <= wr_q + PTR_W'(1);
            if (rd) rd_q <= rd_q + PTR_W'(1);
            case ({wr, rd})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/spi_rx_dma.sv
// Serial receive DMA top: gates the engine on the enables and picks the
// data line. It joins the clock generator, the bit assembler and the FIFO.
// Assumes mode inputs change only while capture is disabled.
module spi_rx_dma
    import spi_rx_dma_pkg::*;
#(
    parameter int MIN_DEPTH = 8,
    parameter int LEN_W     = 2,
    parameter int DIV_W     = 2,
    parameter int MAX_DEPTH = MIN_DEPTH << ((1 << LEN_W) - 1),
    parameter int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              dma_en,
    input  logic              par_mode,
    input  logic              dir_tx,
    input  logic              master,
    input  logic              src_sel,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  div_code,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              sdi0,
    input  logic              sdi1,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              pop,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    logic              cap_en;
    logic              run;
    logic              sdi;
    logic              m_lead;
    logic              at_bnd;
    logic              push;
    logic [BYTE_W-1:0] push_data;

    assign cap_en = link_en & dma_en & ~par_mode & ~dir_tx;
    assign run    = cap_en & master;
    assign sdi    = src_sel ? sdi1 : sdi0;

    spi_rx_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol),
        .div_code(div_code), .full(full), .at_boundary(at_bnd),
        .sck(sck_out), .lead(m_lead)
    );

    spi_rx_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .master(master),
        .cpol(cpol), .sck_in(sck_in), .sdi(sdi), .m_lead(m_lead),
        .at_boundary(at_bnd), .push(push), .push_data(push_data)
    );

    spi_rx_fifo #(.MIN_DEPTH(MIN_DEPTH), .LEN_W(LEN_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .len_code(len_code), .push(push),
        .push_data(push_data), .pop(pop), .pop_valid(pop_valid),
        .pop_data(pop_data), .count(count), .full(full)
    );
endmodule

// File: rtl/spi_rx_dma_chk.sv
// Property checker for spi_rx_dma, attached by bind below.
module spi_rx_dma_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_en,
    input logic             dma_en,
    input logic             par_mode,
    input logic             dir_tx,
    input logic             master,
    input logic             cpol,
    input logic             sck_out,
    input logic             full,
    input logic             pop,
    input logic             pop_valid,
    input logic [CNT_W-1:0] count,
    input logic             at_boundary
);
    logic serial_on;
    logic run_now;

    assign serial_on = link_en & dma_en & ~par_mode;
    assign run_now   = serial_on & ~dir_tx & master;

    // R1: a disabled engine parks SCK at the polarity level.
    p_idle_sck_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_on |=> sck_out == $past(cpol));

    // R7: transmit direction keeps SCK idle.
    p_tx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |=> sck_out == $past(cpol));

    // R4: at a byte boundary with a full FIFO the clock does not move.
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && full && sck_out != cpol && at_boundary)
        |=> (sck_out == $past(sck_out)) || !run_now || !$stable(cpol));

    // R6: a full FIFO does not grow.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> count <= $past(count));

    // R8: the head stays available until popped.
    p_head_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop) |=> pop_valid);

    // R8: at most one byte enters per cycle.
    p_one_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {1'b0, count} <= {1'b0, $past(count)} + (CNT_W + 1)'(1));

    // R9: reset empties the FIFO and idles SCK.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && (sck_out == $past(cpol)));
endmodule

bind spi_rx_dma spi_rx_dma_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .dma_en(dma_en),
    .par_mode(par_mode), .dir_tx(dir_tx), .master(master), .cpol(cpol),
    .sck_out(sck_out), .full(full), .pop(pop), .pop_valid(pop_valid),
    .count(count), .at_boundary(at_bnd)
);

// File: tb/spi_rx_dma_test.sv
module spi_rx_dma_test;
    logic clk = 0;
    logic rst_n = 0;
    logic link_en = 0, dma_en = 0, par_mode = 0, dir_tx = 0, master = 0;
    logic src_sel = 0, cpol = 0, sdi0 = 0, sdi1 = 0, sck_in = 0, pop = 0;
    logic [1:0] div_code = 0, len_code = 0;
    logic sck_out, pop_valid, full;
    logic [7:0] pop_data;
    logic [6:0] count;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_rx_dma uut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .dma_en(dma_en),
        .par_mode(par_mode), .dir_tx(dir_tx), .master(master), .src_sel(src_sel),
        .cpol(cpol), .div_code(div_code), .len_code(len_code), .sdi0(sdi0),
        .sdi1(sdi1), .sck_in(sck_in), .sck_out(sck_out), .pop(pop),
        .pop_valid(pop_valid), .pop_data(pop_data), .count(count), .full(full)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on rising edges.
    int         m_div, m_bits, m_h;
    logic       m_sck, m_prev, m_s, m_en, m_fl, m_lead, m_push;
    logic [7:0] m_sh, m_pb;
    logic [7:0] q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sck = cpol; m_div = 0; m_bits = 0; m_sh = 0; m_prev = cpol;
            q.delete();
        end else begin
            m_s    = src_sel ? sdi1 : sdi0;
            m_en   = link_en && dma_en && !par_mode && !dir_tx;
            m_fl   = q.size() >= (8 << len_code);
            m_lead = 0;
            m_push = 0;
            if (m_en && master) begin
                m_h = 1 << div_code;
                if (!(m_fl && m_sck != cpol && m_bits == 0)) begin
                    if (m_div == m_h - 1) begin
                        m_div = 0;
                        m_sck = !m_sck;
                        m_lead = (m_sck != cpol);
                    end else m_div++;
                end
            end else begin
                m_sck = cpol; m_div = 0;
            end
            if (m_en && !master && m_prev == cpol && sck_in != cpol) m_lead = 1;
            m_prev = sck_in;
            if (!m_en) begin
                m_bits = 0; m_sh = 0;
            end else if (m_lead) begin
                m_pb = {m_sh[6:0], m_s};
                m_sh = m_pb;
                m_bits = (m_bits + 1) % 8;
                m_push = (m_bits == 0);
            end
            if (pop && q.size() > 0) void'(q.pop_front());
            if (m_push && !m_fl) q.push_back(m_pb);
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sck_out === m_sck, "R3 sck", int'(sck_out), int'(m_sck));
            check(count == 7'(q.size()), "R6 count", int'(count), q.size());
            check(full === (q.size() >= (8 << len_code)), "R6 full", int'(full), int'(q.size() >= (8 << len_code)));
            check(pop_valid === (q.size() > 0), "R8 pop_valid", int'(pop_valid), int'(q.size() > 0));
            if (q.size() > 0) check(pop_data == q[0], "R8 pop_data", int'(pop_data), int'(q[0]));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_one(output logic [7:0] d);
        d = pop_data;
        pop = 1;
        @(negedge clk);
        pop = 0;
    endtask

    task automatic flush();
        logic [7:0] d;
        link_en = 0;
        cyc(2);
        for (int i = 0; i < 80 && pop_valid; i++) pop_one(d);
    endtask

    task automatic wait_count(input int n);
        for (int i = 0; i < 20000 && count != 7'(n); i++) @(negedge clk);
    endtask

    task automatic slave_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sdi1 = b[i];
            sck_in = cpol;
            cyc(2);
            sck_in = ~cpol;
            cyc(2);
        end
        sck_in = cpol;
        cyc(2);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] exp_q[$];
        int t0, t1;
        cyc(4);
        // R9: reset state
        check(count == 0, "R9 count in reset", int'(count), 0);
        check(pop_valid == 0, "R9 pop_valid in reset", int'(pop_valid), 0);
        check(sck_out == cpol, "R9 sck in reset", int'(sck_out), int'(cpol));
        rst_n = 1;

        // R1: transfer enable low, then parallel mode selected
        master = 1; link_en = 1; dma_en = 0; sdi0 = 1;
        cyc(60);
        check(count == 0 && sck_out == 0, "R1 dma_en low", int'(count), 0);
        dma_en = 1; par_mode = 1;
        cyc(60);
        check(count == 0 && sck_out == 0, "R1 par_mode high", int'(count), 0);

        // R7: transmit direction blocks capture
        par_mode = 0; dir_tx = 1;
        cyc(60);
        check(count == 0 && sck_out == 0, "R7 tx direction", int'(count), 0);

        // R2, R4, R6: master, line 0 all ones, depth 8, stall at inverse of cpol
        dir_tx = 0; sdi1 = 0;
        wait_count(8);
        cyc(40);
        check(count == 8, "R6 depth 8 reached", int'(count), 8);
        check(sck_out == 1, "R4 parked level cpol=0", int'(sck_out), 1);
        pop_one(d);
        check(d == 8'hFF, "R2 line 0 byte", int'(d), 255);
        t0 = 0;
        for (int i = 0; i < 20 && sck_out == 1; i++) begin cyc(1); t0++; end
        check(sck_out == 0, "R4 clock resumes after pop", int'(sck_out), 0);
        wait_count(8);
        flush();
        // R2: line 1 selected
        src_sel = 1; link_en = 1;
        wait_count(3);
        flush();
        pop_one(d);
        check(count == 0, "R8 flush empties", int'(count), 0);
        link_en = 1;
        wait_count(2);
        link_en = 0;
        cyc(2);
        pop_one(d);
        check(d == 8'h00, "R2 line 1 byte", int'(d), 0);
        flush();

        // R3: half period 4 and 8 with cpol=1, depth 64
        cpol = 1; len_code = 3; div_code = 2; src_sel = 0;
        cyc(2);
        link_en = 1;
        while (sck_out == 1) @(negedge clk);
        t0 = $time;
        while (sck_out == 0) @(negedge clk);
        t1 = $time;
        check((t1 - t0) / 8 == 4, "R3 half period div 2", (t1 - t0) / 8, 4);
        link_en = 0; div_code = 3; cyc(2); link_en = 1;
        while (sck_out == 1) @(negedge clk);
        t0 = $time;
        while (sck_out == 0) @(negedge clk);
        t1 = $time;
        check((t1 - t0) / 8 == 8, "R3 half period div 3", (t1 - t0) / 8, 8);
        wait_count(64);
        cyc(40);
        check(count == 64, "R6 depth 64 reached", int'(count), 64);
        check(sck_out == 0, "R4 parked level cpol=1", int'(sck_out), 0);
        flush();

        // R6: depth 16 and 32
        cpol = 0; div_code = 0; len_code = 1;
        cyc(2); link_en = 1;
        wait_count(16); cyc(40);
        check(count == 16 && full, "R6 depth 16", int'(count), 16);
        flush();
        len_code = 2; link_en = 1;
        wait_count(32); cyc(40);
        check(count == 32 && full, "R6 depth 32", int'(count), 32);
        flush();

        // R5: slave mode, depth 8, ten bytes on line 1
        master = 0; len_code = 0; src_sel = 1; sck_in = 0;
        cyc(3); link_en = 1;
        for (int i = 0; i < 10; i++) slave_byte(8'hA1 + 8'(i));
        check(count == 8, "R5 overflow bytes dropped", int'(count), 8);
        for (int i = 0; i < 2; i++) begin
            pop_one(d);
            check(d == 8'hA1 + 8'(i), "R5 head order", int'(d), 161 + i);
        end
        slave_byte(8'h55);
        slave_byte(8'h3C);
        for (int i = 2; i < 8; i++) exp_q.push_back(8'hA1 + 8'(i));
        exp_q.push_back(8'h55);
        exp_q.push_back(8'h3C);
        foreach (exp_q[i]) begin
            pop_one(d);
            check(d == exp_q[i], "R5 stored after space", int'(d), int'(exp_q[i]));
        end
        // R2: slave with cpol=1 samples on falling edges
        link_en = 0; cpol = 1; sck_in = 1;
        cyc(3); link_en = 1;
        slave_byte(8'h96);
        pop_one(d);
        check(d == 8'h96, "R2 slave cpol=1 byte", int'(d), 150);

        cyc(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule